// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the current in one H-bridge of a stepper driver. When enabled, it turns the diagonal source/sink pair on. Current then builds in the winding until an external digital comparator reports that the trip level has been reached. The trip ends the on phase and starts a decay period of programmed length. The decay can be pure slow decay. It can also be a split decay: fast decay for the first 5/16 of the period, then slow decay for the rest. When the period ends, the bridge drives again. A shorted load therefore produces a steady on/trip/off pattern instead of runaway current.

The comparator input is masked for a programmed number of cycles at the start of each on phase, so switching transients cannot end it early. During decay, a rectification flag tells the gate stage to turn the free-wheeling FETs on actively. The flag is withheld while the near-zero-current flag is high, so the winding current cannot reverse. Both the decay length and the decay style are taken at the moment of the trip. The indexer may therefore change them at any time without disturbing a decay that is already running.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst_n` is low, and in every cycle after a clock edge that sampled `bridge_en` low, `bridge_cmd` is 0 (all-off) and `sr_en` is 0.
- R2: An on phase drives `bridge_cmd` = 1 (drive). It starts on the clock edge after `bridge_en` is first sampled high. It continues until a trip is accepted.
- R3: In the first `blank_cycles` cycles of every on phase, `trip_in` is ignored. With `trip_in` held high, an on phase lasts exactly `blank_cycles`+1 cycles.
- R4: An accepted trip starts a decay of exactly `off_cycles` cycles, where a value of 0 counts as 1. Drive resumes in the cycle that follows.
- R5: With `decay_mixed` = 0 sampled at the trip, every decay cycle shows `bridge_cmd` = 3 (slow).
- R6: With `decay_mixed` = 1 sampled at the trip, the first floor(`off_cycles`*5/16) decay cycles show `bridge_cmd` = 2 (fast) and the rest show 3 (slow). A fast cycle never follows a slow one within the same decay.
- R7: `off_cycles` and `decay_mixed` are sampled at the accepted trip. Changing them during a decay has no effect on that decay.
- R8: `sr_en` is 1 exactly in decay cycles where `near_zero` is 0. It is 0 while driving or all-off.
- R9: With `trip_in` held high (shorted load), the chopper keeps cycling through drive and decay periods. Each on phase lasts `blank_cycles`+1 cycles.
- R10: Dropping `bridge_en` for one cycle during any phase aborts it to all-off. On re-enable, the chopper starts a fresh on phase with full blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_en | input | 1 | High lets the bridge run; low forces all-off and clears the timers |
| trip_in | input | 1 | Current comparator output, high at or above trip level |
| decay_mixed | input | 1 | 1 = split fast/slow decay, 0 = slow decay only |
| near_zero | input | 1 | High when the winding current is close to zero |
| off_cycles | input | OFF_W | Decay length in clock cycles |
| blank_cycles | input | BLANK_W | Comparator mask length in clock cycles |
| bridge_cmd | output | 2 | 0 all-off, 1 drive, 2 fast decay, 3 slow decay |
| sr_en | output | 1 | Synchronous rectification enable during decay |

## Verification
The bench holds the trip high so that the cycle length of blanking and decay is exposed. An off-by-one in either counter shifts every later phase and is caught within one period. It changes the decay length and style in the middle of a decay. A design that reads them live would end the decay early or switch between fast and slow in the wrong cycle. It also drives a zero decay length and a length short enough that the fast share rounds to zero; a design without those guards would hang in decay or emit a stray fast cycle. Finally, it toggles the near-zero flag and drops the enable mid-phase. Any leak of the rectification flag outside decay, or a restart without full blanking, shows up as a wrong code.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    CMD_OFF   = 2'd0,
    CMD_DRIVE = 2'd1,
    CMD_FAST  = 2'd2,
    CMD_SLOW  = 2'd3
  } bridge_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_DECAY = 2'd2
  } phase_e;

  // fast share of a decay of n cycles: floor(n * 5 / 16)
  function automatic logic [31:0] fast_share(input logic [31:0] n);
    logic [34:0] prod;
    prod = {3'b000, n} * 35'd5;
    return prod[35-1:4] == '0 ? 32'd0 : prod[35-1-3:4];
  endfunction

  // a zero length still yields one decay cycle
  function automatic logic [31:0] eff_len(input logic [31:0] n);
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

endpackage

// File: rtl/chop_blank.sv
module chop_blank #(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               load,
  input  logic [BLANK_W-1:0] load_val,
  input  logic               trip_raw,
  output logic               trip_ok,
  output logic               blanking
);

  logic [BLANK_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign blanking = (cnt_q != '0);
  assign trip_ok  = trip_raw && !blanking;

  AST_BLANK_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !clear && !load) |=> (cnt_q < $past(cnt_q))) else $error("blank count stuck"); // R3

endmodule

// File: rtl/chop_offtimer.sv
module chop_offtimer #(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic [OFF_W-1:0] len_in,
  input  logic             mixed_in,
  output logic             running,
  output logic             last,
  output logic             in_fast
);

  logic [OFF_W-1:0] tim_q;
  logic [OFF_W-1:0] len_q;
  logic [OFF_W-1:0] fast_q;
  logic             mixed_q;
  logic [OFF_W-1:0] len_eff;
  logic [OFF_W-1:0] fast_len;

  assign len_eff  = OFF_W'(chop_pkg::eff_len(32'(len_in)));
  assign fast_len = OFF_W'(chop_pkg::fast_share(32'(len_in)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tim_q   <= '0;
      len_q   <= '0;
      fast_q  <= '0;
      mixed_q <= 1'b0;
    end else if (clear) begin
      running <= 1'b0;
      tim_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      tim_q   <= '0;
      len_q   <= len_eff;
      fast_q  <= fast_len;
      mixed_q <= mixed_in;
    end else if (running) begin
      if (last) begin
        running <= 1'b0;
        tim_q   <= '0;
      end else begin
        tim_q <= tim_q + 1'b1;
      end
    end
  end

  assign last    = running && (tim_q == len_q - 1'b1);
  assign in_fast = running && mixed_q && (tim_q < fast_q);

  AST_NO_FAST_AFTER_SLOW: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (running && !in_fast && !last) |=> !in_fast) else $error("fast after slow"); // R6
  AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (running && !last && !start) |=> ($stable(len_q) && $stable(mixed_q))) else $error("config moved"); // R7

endmodule

// File: rtl/chop_decode.sv
module chop_decode (
  input  chop_pkg::phase_e phase,
  input  logic             in_fast,
  input  logic             near_zero,
  output logic [1:0]       cmd,
  output logic             sr_en
);
  import chop_pkg::*;

  always_comb begin
    unique case (phase)
      PH_ON:    cmd = CMD_DRIVE;
      PH_DECAY: cmd = in_fast ? CMD_FAST : CMD_SLOW;
      default:  cmd = CMD_OFF;
    endcase
  end

  assign sr_en = (phase == PH_DECAY) && !near_zero;

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper #(
  parameter int OFF_W   = 12,
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bridge_en,
  input  logic               trip_in,
  input  logic               decay_mixed,
  input  logic               near_zero,
  input  logic [OFF_W-1:0]   off_cycles,
  input  logic [BLANK_W-1:0] blank_cycles,
  output logic [1:0]         bridge_cmd,
  output logic               sr_en
);
  import chop_pkg::*;

  phase_e phase_q;
  logic   trip_ok;
  logic   blanking;
  logic   off_running;
  logic   off_last;
  logic   off_fast;
  logic   blank_load;
  logic   off_start;

  assign blank_load = bridge_en && ((phase_q == PH_IDLE) || (phase_q == PH_DECAY && off_last));
  assign off_start  = bridge_en && (phase_q == PH_ON) && trip_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= PH_IDLE;
    else if (!bridge_en) phase_q <= PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE:  phase_q <= PH_ON;
        PH_ON:    if (trip_ok)  phase_q <= PH_DECAY;
        PH_DECAY: if (off_last) phase_q <= PH_ON;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  chop_blank #(.BLANK_W(BLANK_W)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!bridge_en),
    .load     (blank_load),
    .load_val (blank_cycles),
    .trip_raw (trip_in),
    .trip_ok  (trip_ok),
    .blanking (blanking)
  );

  chop_offtimer #(.OFF_W(OFF_W)) u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!bridge_en),
    .start    (off_start),
    .len_in   (off_cycles),
    .mixed_in (decay_mixed),
    .running  (off_running),
    .last     (off_last),
    .in_fast  (off_fast)
  );

  chop_decode u_dec (
    .phase     (phase_q),
    .in_fast   (off_fast),
    .near_zero (near_zero),
    .cmd       (bridge_cmd),
    .sr_en     (sr_en)
  );

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |=> (bridge_cmd == CMD_OFF && !sr_en)) else $error("not off"); // R1
  AST_BLANK_HOLDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON && blanking && bridge_en) |=> (phase_q == PH_ON)) else $error("blank leak"); // R3
  AST_DECAY_FROM_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECAY && $past(phase_q) != PH_DECAY) |-> ($past(phase_q) == PH_ON && $past(trip_in))) else $error("decay without trip"); // R2
  AST_RESTART_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (off_last && bridge_en) |=> (bridge_cmd == CMD_DRIVE)) else $error("no restart"); // R4
  AST_SR_ONLY_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_en |-> (off_running && phase_q == PH_DECAY)) else $error("sr outside decay"); // R8

endmodule

// File: tb/test_offtime_chopper.sv
module test_offtime_chopper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bridge_en;
  logic        trip_in;
  logic        decay_mixed;
  logic        near_zero;
  logic [11:0] off_cycles;
  logic [7:0]  blank_cycles;
  logic [1:0]  bridge_cmd;
  logic        sr_en;

  always #5 clk = ~clk;

  offtime_chopper i_offtime_chopper (
    .clk          (clk),
    .rst_n        (rst_n),
    .bridge_en    (bridge_en),
    .trip_in      (trip_in),
    .decay_mixed  (decay_mixed),
    .near_zero    (near_zero),
    .off_cycles   (off_cycles),
    .blank_cycles (blank_cycles),
    .bridge_cmd   (bridge_cmd),
    .sr_en        (sr_en)
  );

  typedef struct {
    logic [1:0] cmd;
    logic       sr;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // reference model: phase 0 off, 1 on, 2 decay; age = cycles spent in phase
  int m_st = 0, m_age = 0, m_len = 1, m_fast = 0;
  bit m_mix = 0;

  function automatic logic [1:0] model_cmd();
    if (m_st == 0) return 2'd0;
    if (m_st == 1) return 2'd1;
    return (m_mix && m_age < m_fast) ? 2'd2 : 2'd3;
  endfunction

  task automatic model_edge();
    if (!rst_n || !bridge_en) begin
      m_st = 0; m_age = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_age = 0;
    end else if (m_st == 1) begin
      if (m_age >= int'(blank_cycles) && trip_in) begin
        m_st   = 2;
        m_age  = 0;
        m_len  = (off_cycles == 0) ? 1 : int'(off_cycles);
        m_fast = (int'(off_cycles) * 5) / 16;
        m_mix  = decay_mixed;
      end else m_age++;
    end else begin
      if (m_age + 1 >= m_len) begin m_st = 1; m_age = 0; end
      else m_age++;
    end
  endtask

  // driver: apply inputs, let one edge pass, push the expected output
  task automatic step(input logic en, input logic trip, input logic nz, input string tag);
    exp_t e;
    bridge_en = en;
    trip_in   = trip;
    near_zero = nz;
    @(posedge clk);
    model_edge();
    e.cmd = model_cmd();
    e.sr  = (m_st == 2) && !nz;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      total++;
      if (bridge_cmd !== e.cmd || sr_en !== e.sr) begin
        bad++;
        $display("FAIL %s: cmd=%0d sr=%0d expected cmd=%0d sr=%0d at %0t",
                 e.tag, bridge_cmd, sr_en, e.cmd, e.sr, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bridge_en = 1'b0; trip_in = 1'b0; near_zero = 1'b0;
    decay_mixed = 1'b1; off_cycles = 12'd16; blank_cycles = 8'd4;
    // R1: reset state, then disabled
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R1 reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R1 disabled");

    // blank 4, decay 16 split: on lasts 5 cycles, 5 fast then 11 slow
    for (int i = 0; i < 6; i++)  step(1'b1, 1'b1, 1'b0, "R3 blank then trip");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b0, "R6 split decay");
    for (int i = 0; i < 5; i++)  step(1'b1, 1'b1, 1'b0, "R4 restart");
    for (int i = 0; i < 45; i++) step(1'b1, 1'b1, 1'b0, "R9 shorted load");

    // slow only
    decay_mixed = 1'b0; off_cycles = 12'd10;
    step(1'b0, 1'b1, 1'b0, "R10 disable");
    for (int i = 0; i < 35; i++) step(1'b1, 1'b1, 1'b0, "R5 slow decay");

    // blanking masks early trips, on phase holds without trip
    blank_cycles = 8'd5; decay_mixed = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R1 disabled");
    for (int i = 0; i < 4; i++)  step(1'b1, 1'b1, 1'b0, "R3 masked trip");
    for (int i = 0; i < 8; i++)  step(1'b1, 1'b0, 1'b0, "R2 hold drive");
    for (int i = 0; i < 2; i++)  step(1'b1, 1'b1, 1'b0, "R2 trip ends drive");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0, "R2 decay and resume");

    // config change inside a decay
    off_cycles = 12'd32; blank_cycles = 8'd1;
    step(1'b0, 1'b0, 1'b0, "R1 disabled");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R7 trip");
    decay_mixed = 1'b0; off_cycles = 12'd3;
    for (int i = 0; i < 34; i++) step(1'b1, 1'b0, 1'b0, "R7 latched config");

    // near-zero gating of rectification
    decay_mixed = 1'b1; off_cycles = 12'd12;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, (i % 3) == 0, "R8 near zero");

    // zero length and zero fast share
    off_cycles = 12'd0; blank_cycles = 8'd0;
    step(1'b0, 1'b1, 1'b0, "R1 disabled");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, "R4 zero length");
    off_cycles = 12'd3;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, "R6 no fast share");

    // abort mid-decay and restart with full blanking
    off_cycles = 12'd40; blank_cycles = 8'd3;
    step(1'b0, 1'b1, 1'b0, "R1 disabled");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b1, 1'b0, "R10 run");
    step(1'b0, 1'b1, 1'b0, "R10 abort");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, "R10 fresh start");

    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule